// File: doc/BRIEF.md
# Receive Sample Format Packer

This block sits between the receive decimation chain and the host transfer FIFO. Each cycle it may accept one complex sample of 16-bit signed I and Q. The sample comes either from the half-band filtered path or from the unfiltered path. The block applies an arithmetic right shift to each part and cuts it to the selected width. It can drop Q. It then emits 16-bit words, each with a valid strobe, ready for the FIFO.

One 32-bit format word controls all of this. That word is written through a simple write-enable port. A write holding an unsupported value is refused and raises a sticky error flag, and the packer keeps the last accepted format. An accepted format only switches in on a complex-sample boundary. At that point any half-filled 8-bit word is thrown away. The parameter `STRICT_FORMATS` selects which values count as supported. When it is 1 (the default), only the two production formats are accepted. When it is 0, any value with 8-bit or 16-bit width is accepted, with free choice of shift, Q-enable and bypass.

Top module: `rx_sample_packer`

## Requirements
- R1: After reset `pk_valid` and `fmt_error` are low, and the active format is 0x00000300: 16-bit width, shift 0, I and Q both delivered, filtered path.
- R2: The format word is decoded as follows. Bits [3:0] hold the shift. Bits [8:4] hold the width. Bit 9 is Q-enable. Bit 10 selects the unfiltered path. Bits [31:11] must be zero. With `STRICT_FORMATS`=1, only 0x00000300 and 0x00000288 are legal. With `STRICT_FORMATS`=0, any value with zero reserved bits and a width of 8 or 16 is legal.
- R3: A write of an illegal value sets `fmt_error`, which stays high until reset. Such a write leaves the active format unchanged.
- R4: Each sample is shifted right by the shift field, with its sign kept, before the width is reduced.
- R5: In 16-bit mode with Q enabled, a sample accepted at edge N gives the shifted I word after edge N+1 and the shifted Q word after edge N+2.
- R6: In 16-bit mode with Q disabled, each sample gives one word, the shifted I, after the next edge.
- R7: In 8-bit mode with Q enabled, each sample gives one word after the next edge. The upper byte is the low byte of the shifted I, and the lower byte is the low byte of the shifted Q.
- R8: In 8-bit mode with Q disabled, two successive samples make one word, which appears after the second sample. The earlier I goes in the upper byte. The first sample of a pair produces no word.
- R9: When bypass is set, samples are taken from `raw_valid`/`raw_i`/`raw_q`, and the filtered inputs have no effect. When bypass is clear, the reverse holds.
- R10: A legal write becomes active on the second edge after it. This happens only in a cycle with no sample accepted and no Q word pending, and it discards any held half word.
- R11: A sample must not be offered in the cycle in which a 16-bit Q word is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_we | input | 1 | Format register write strobe |
| fmt_wdata | input | 32 | Format word to write |
| flt_valid | input | 1 | Filtered path sample strobe |
| flt_i | input | 16 | Filtered path I, signed |
| flt_q | input | 16 | Filtered path Q, signed |
| raw_valid | input | 1 | Unfiltered path sample strobe |
| raw_i | input | 16 | Unfiltered path I, signed |
| raw_q | input | 16 | Unfiltered path Q, signed |
| pk_valid | output | 1 | Output word strobe |
| pk_word | output | 16 | Packed output word |
| fmt_error | output | 1 | Sticky illegal-format flag |

## Verification
The bench drives negative samples with nonzero shifts. A logical shift in place of an arithmetic one would put zeros into the upper bits of I and Q. It sends an odd number of I-only 8-bit samples and then changes format. A packer that kept the stale half byte would pair it with the first sample in the new format, and every later byte would be out of place. It writes values with reserved bits set, with unsupported widths, and with shifts the strict build refuses. A design that accepted any of them would change the output bytes right after the write. It also sends samples on the path that is not selected, and a design that did not gate by bypass would emit extra words.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int SMP_W    = 16;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int FMT_W    = 32;
    localparam int SH_W     = 4;
    localparam int WID_W    = 5;
    localparam int USED_W   = SH_W + WID_W + 2;
    localparam int LANES    = 2;

    localparam logic [FMT_W-1:0] FMT_DEFAULT = 32'h0000_0300;
    localparam logic [FMT_W-1:0] FMT_NARROW  = 32'h0000_0288;

    // packed order matches the register bit order from bit 10 down to bit 0
    typedef struct packed {
        logic             bypass;
        logic             want_q;
        logic [WID_W-1:0] width;
        logic [SH_W-1:0]  shift;
    } fmt_t;

    function automatic fmt_t fmt_decode(input logic [FMT_W-1:0] w);
        return fmt_t'(w[USED_W-1:0]);
    endfunction

    function automatic logic fmt_legal(input logic [FMT_W-1:0] w, input logic strict);
        fmt_t f;
        f = fmt_decode(w);
        if (|w[FMT_W-1:USED_W]) return 1'b0;
        if (strict) return (w == FMT_DEFAULT) || (w == FMT_NARROW);
        return (f.width == WID_W'(BYTE_W)) || (f.width == WID_W'(WORD_W));
    endfunction

    function automatic logic [SMP_W-1:0] ashr(input logic [SMP_W-1:0] x,
                                              input logic [SH_W-1:0] s);
        return SMP_W'($signed(x) >>> s);
    endfunction
endpackage

// File: rtl/rxp_lane_shift.sv
module rxp_lane_shift
    import rxp_pkg::*;
(
    input  logic [SMP_W-1:0] din,
    input  logic [SH_W-1:0]  sh,
    output logic [SMP_W-1:0] dout
);
    always_comb dout = ashr(din, sh);
endmodule

// File: rtl/rxp_fmt_reg.sv
module rxp_fmt_reg
    import rxp_pkg::*;
#(
    parameter bit STRICT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [FMT_W-1:0] wdata,
    input  logic             boundary_ok,
    output fmt_t             active,
    output logic             apply,
    output logic             fmt_error
);
    fmt_t pend;
    logic pend_v;
    logic legal;

    always_comb legal = fmt_legal(wdata, STRICT);
    always_comb apply = pend_v && boundary_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= fmt_decode(FMT_DEFAULT);
            pend      <= fmt_decode(FMT_DEFAULT);
            pend_v    <= 1'b0;
            fmt_error <= 1'b0;
        end else begin
            if (apply) active <= pend;
            if (we && legal) begin
                pend   <= fmt_decode(wdata);
                pend_v <= 1'b1;
            end else if (apply) begin
                pend_v <= 1'b0;
            end
            if (we && !legal) fmt_error <= 1'b1;
        end
    end

    // R3: error flag, once set, never drops before reset
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        fmt_error |=> fmt_error);
    // R3: refused write raises the flag on the next edge
    a_r3_flag_raise: assert property (@(posedge clk) disable iff (rst)
        (we && !legal) |=> fmt_error);
    // R10: active format only moves on a boundary
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(active));
endmodule

// File: rtl/rxp_pack.sv
module rxp_pack
    import rxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_t              fmt,
    input  logic              apply,
    input  logic              take,
    input  logic [SMP_W-1:0]  si,
    input  logic [SMP_W-1:0]  sq,
    output logic              q_busy,
    output logic              pk_valid,
    output logic [WORD_W-1:0] pk_word
);
    logic [SMP_W-1:0]  q_hold;
    logic              half_v;
    logic [BYTE_W-1:0] half_b;
    logic              narrow;

    always_comb narrow = (fmt.width == WID_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            q_busy   <= 1'b0;
            q_hold   <= '0;
            half_v   <= 1'b0;
            half_b   <= '0;
            pk_valid <= 1'b0;
            pk_word  <= '0;
        end else begin
            pk_valid <= 1'b0;
            if (q_busy) begin
                pk_valid <= 1'b1;
                pk_word  <= WORD_W'(q_hold);
                q_busy   <= 1'b0;
            end else if (take) begin
                if (narrow) begin
                    if (fmt.want_q) begin
                        pk_valid <= 1'b1;
                        pk_word  <= {si[BYTE_W-1:0], sq[BYTE_W-1:0]};
                    end else if (half_v) begin
                        pk_valid <= 1'b1;
                        pk_word  <= {half_b, si[BYTE_W-1:0]};
                        half_v   <= 1'b0;
                    end else begin
                        half_b <= si[BYTE_W-1:0];
                        half_v <= 1'b1;
                    end
                end else begin
                    pk_valid <= 1'b1;
                    pk_word  <= WORD_W'(si);
                    if (fmt.want_q) begin
                        q_busy <= 1'b1;
                        q_hold <= sq;
                    end
                end
            end
            if (apply) half_v <= 1'b0;
        end
    end

    // R11: upstream keeps samples away from a pending Q slot
    a_r11_spacing: assert property (@(posedge clk) disable iff (rst)
        q_busy |-> !take);
    // R5: pending Q word leaves on the very next edge
    a_r5_q_follows: assert property (@(posedge clk) disable iff (rst)
        q_busy |=> (pk_valid && !q_busy));
    // R8: the first sample of an I-only byte pair emits nothing
    a_r8_first_silent: assert property (@(posedge clk) disable iff (rst)
        (take && !q_busy && narrow && !fmt.want_q && !half_v) |=> !pk_valid);
    // R10: a format switch never lands while a Q word is owed
    a_r10_boundary: assert property (@(posedge clk) disable iff (rst)
        apply |-> (!q_busy && !take));
endmodule

// File: rtl/rx_sample_packer.sv
module rx_sample_packer
    import rxp_pkg::*;
#(
    parameter bit STRICT_FORMATS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_we,
    input  logic [FMT_W-1:0]  fmt_wdata,
    input  logic              flt_valid,
    input  logic [SMP_W-1:0]  flt_i,
    input  logic [SMP_W-1:0]  flt_q,
    input  logic              raw_valid,
    input  logic [SMP_W-1:0]  raw_i,
    input  logic [SMP_W-1:0]  raw_q,
    output logic              pk_valid,
    output logic [WORD_W-1:0] pk_word,
    output logic              fmt_error
);
    fmt_t             fmt;
    logic             apply;
    logic             take;
    logic             q_busy;
    logic             boundary_ok;
    logic [SMP_W-1:0] lane_in  [LANES];
    logic [SMP_W-1:0] lane_out [LANES];

    // R9: source selection follows the active bypass bit
    always_comb begin
        take       = fmt.bypass ? raw_valid : flt_valid;
        lane_in[0] = fmt.bypass ? raw_i : flt_i;
        lane_in[1] = fmt.bypass ? raw_q : flt_q;
    end

    always_comb boundary_ok = !q_busy && !take;

    rxp_fmt_reg #(.STRICT(STRICT_FORMATS)) u_fmt (
        .clk        (clk),
        .rst        (rst),
        .we         (fmt_we),
        .wdata      (fmt_wdata),
        .boundary_ok(boundary_ok),
        .active     (fmt),
        .apply      (apply),
        .fmt_error  (fmt_error)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rxp_lane_shift u_sh (
            .din (lane_in[g]),
            .sh  (fmt.shift),
            .dout(lane_out[g])
        );
    end

    rxp_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt),
        .apply   (apply),
        .take    (take),
        .si      (lane_out[0]),
        .sq      (lane_out[1]),
        .q_busy  (q_busy),
        .pk_valid(pk_valid),
        .pk_word (pk_word)
    );

    // R9: with the filtered path selected and idle, unfiltered strobes add no word
    a_r9_path_gate: assert property (@(posedge clk) disable iff (rst)
        (!fmt.bypass && !flt_valid && !q_busy && !apply) |=> !pk_valid);
endmodule

// File: tb/rx_sample_packer_test.sv
module rx_sample_packer_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        we0 = 1'b0, we1 = 1'b0;
    logic [31:0] wdata = '0;
    logic        fv = 1'b0, rv = 1'b0;
    logic [15:0] fi = '0, fq = '0, ri = '0, rq = '0;
    logic        v0, v1, e0, e1;
    logic [15:0] w0, w1;

    rx_sample_packer uut (
        .clk(clk), .rst(rst), .fmt_we(we0), .fmt_wdata(wdata),
        .flt_valid(fv), .flt_i(fi), .flt_q(fq),
        .raw_valid(rv), .raw_i(ri), .raw_q(rq),
        .pk_valid(v0), .pk_word(w0), .fmt_error(e0));

    rx_sample_packer #(.STRICT_FORMATS(1'b0)) uut_open (
        .clk(clk), .rst(rst), .fmt_we(we1), .fmt_wdata(wdata),
        .flt_valid(fv), .flt_i(fi), .flt_q(fq),
        .raw_valid(rv), .raw_i(ri), .raw_q(rq),
        .pk_valid(v1), .pk_word(w1), .fmt_error(e1));

    int errors = 0, checks = 0, cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural model state per instance
    int   mw[2], ms[2];
    bit   mq[2], mb[2], mh[2], merr[2], mfresh[2];
    logic [7:0] mhb[2];
    logic [15:0] eq0[$], eq1[$];
    int          ec0[$], ec1[$];
    string       et0[$], et1[$];

    function automatic logic [15:0] sh(input logic [15:0] x, input int s);
        logic signed [15:0] t;
        t = $signed(x);
        for (int n = 0; n < s; n++) t = {t[15], t[15:1]};
        return t;
    endfunction

    function automatic bit legal_m(input int k, input logic [31:0] w);
        if (w[31:11] != 0) return 1'b0;
        if (k == 0) return (w == 32'h300) || (w == 32'h288);
        return (w[8:4] == 5'd8) || (w[8:4] == 5'd16);
    endfunction

    task automatic push(input int k, input logic [15:0] w, input int c, input string t);
        if (k == 0) begin eq0.push_back(w); ec0.push_back(c); et0.push_back(t); end
        else        begin eq1.push_back(w); ec1.push_back(c); et1.push_back(t); end
    endtask

    function automatic string tag_of(input int k);
        string t;
        if (mb[k]) t = "R9";
        else if (mw[k] == 16) t = mq[k] ? "R5" : "R6";
        else t = mq[k] ? "R7" : "R8";
        if (ms[k] != 0) t = {t, "/R4"};
        if (mfresh[k]) t = {t, "/R10"};
        return t;
    endfunction

    task automatic model_sample(input int k, input int c);
        bit v;
        logic [15:0] si, sq;
        string t;
        v  = mb[k] ? rv : fv;
        if (!v) return;
        si = sh(mb[k] ? ri : fi, ms[k]);
        sq = sh(mb[k] ? rq : fq, ms[k]);
        t  = tag_of(k);
        if (mw[k] == 16) begin
            push(k, si, c + 1, t);
            if (mq[k]) push(k, sq, c + 2, t);
            mfresh[k] = 1'b0;
        end else if (mq[k]) begin
            push(k, {si[7:0], sq[7:0]}, c + 1, t);
            mfresh[k] = 1'b0;
        end else if (mh[k]) begin
            push(k, {mhb[k], si[7:0]}, c + 1, t);
            mh[k] = 1'b0;
            mfresh[k] = 1'b0;
        end else begin
            mhb[k] = si[7:0];
            mh[k]  = 1'b1;
        end
    endtask

    // compare outputs against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (v0) begin
                checks++;
                if (eq0.size() == 0) begin
                    errors++;
                    $display("FAIL uut spurious word: actual %h expected none (R9)", w0);
                end else begin
                    logic [15:0] ew; int ecc; string et;
                    ew = eq0.pop_front(); ecc = ec0.pop_front(); et = et0.pop_front();
                    if (w0 !== ew || cyc != ecc) begin
                        errors++;
                        $display("FAIL uut %s: actual %h@%0d expected %h@%0d", et, w0, cyc, ew, ecc);
                    end
                end
            end
            if (v1) begin
                checks++;
                if (eq1.size() == 0) begin
                    errors++;
                    $display("FAIL uut_open spurious word: actual %h expected none (R9)", w1);
                end else begin
                    logic [15:0] ew; int ecc; string et;
                    ew = eq1.pop_front(); ecc = ec1.pop_front(); et = et1.pop_front();
                    if (w1 !== ew || cyc != ecc) begin
                        errors++;
                        $display("FAIL uut_open %s: actual %h@%0d expected %h@%0d", et, w1, cyc, ew, ecc);
                    end
                end
            end
        end
    end

    task automatic check_err;
        checks++;
        if (e0 !== merr[0]) begin
            errors++;
            $display("FAIL R3 uut fmt_error: actual %b expected %b", e0, merr[0]);
        end
        checks++;
        if (e1 !== merr[1]) begin
            errors++;
            $display("FAIL R3 uut_open fmt_error: actual %b expected %b", e1, merr[1]);
        end
    endtask

    task automatic wr(input int k, input logic [31:0] w);
        @(negedge clk);
        wdata = w;
        if (k == 0) we0 = 1'b1; else we1 = 1'b1;
        if (legal_m(k, w)) begin
            mb[k] = w[10]; mq[k] = w[9]; mw[k] = int'(w[8:4]); ms[k] = int'(w[3:0]);
            if (mh[k]) mfresh[k] = 1'b1;
            mh[k] = 1'b0;
        end else begin
            merr[k] = 1'b1;
        end
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
        repeat (2) @(negedge clk);
        check_err();
    endtask

    // one sample then one idle cycle keeps R11 spacing
    task automatic send(input bit f, input bit r);
        @(negedge clk);
        fi = 16'($urandom); fq = 16'($urandom);
        ri = 16'($urandom); rq = 16'($urandom);
        fv = f; rv = r;
        model_sample(0, cyc);
        model_sample(1, cyc);
        @(negedge clk);
        fv = 1'b0; rv = 1'b0;
    endtask

    initial begin
        void'($urandom(7));
        for (int k = 0; k < 2; k++) begin
            mw[k] = 16; ms[k] = 0; mq[k] = 1; mb[k] = 0;
            mh[k] = 0; merr[k] = 0; mfresh[k] = 0; mhb[k] = '0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        checks++;
        if (v0 !== 1'b0 || v1 !== 1'b0) begin
            errors++;
            $display("FAIL R1 pk_valid after reset: actual %b%b expected 00", v0, v1);
        end
        check_err();
        // R1 default format: 16-bit I then Q, filtered path
        repeat (6) send(1'b1, 1'b1);
        // R7 with R4 shift 8 on strict; R6 with shift 5 on open
        wr(0, 32'h288);
        wr(1, 32'h105);
        repeat (6) send(1'b1, 1'b1);
        // R3: reserved bit, and a shift the strict set refuses
        wr(0, 32'h288 | 32'h800);
        wr(0, 32'h301);
        repeat (3) send(1'b1, 1'b0);
        // R8: I-only bytes, odd count leaves a half word
        wr(1, 32'h085);
        repeat (5) send(1'b1, 1'b0);
        // R10 drops the half word; R9 bypass takes the unfiltered path
        wr(1, 32'h485);
        repeat (4) send(1'b0, 1'b1);
        repeat (3) send(1'b1, 1'b0);
        repeat (3) send(1'b1, 1'b1);
        // R2: width 12 is not in the open set either
        wr(1, 32'h0C5);
        repeat (2) send(1'b0, 1'b1);
        wr(0, 32'h300);
        wr(1, 32'h300);
        repeat (4) send(1'b1, 1'b1);
        repeat (4) @(negedge clk);
        checks++;
        if (eq0.size() != 0 || eq1.size() != 0) begin
            errors++;
            $display("FAIL R5 words missing: actual %0d/%0d left expected 0/0", eq0.size(), eq1.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished (R1)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule